// File: doc/BRIEF.md
# SPI Client Shift Engine

This block is the serial core of an SPI client. It runs on a fast system clock. It passes the SCK, MOSI and active-low select inputs through a short synchronizer. It then finds the sample edges and the change edges of the serial clock from static polarity and phase inputs. Bytes are assembled most-significant or least-significant bit first, as a static order input selects. Each completed byte goes into a small receive buffer with a valid/ready read side. The byte to be sent back on MISO is taken from a holding input, and a one-cycle pulse marks the moment it is taken.

Two frame formats are available. The plain format stores every byte of a frame. The address format uses the first byte after select assertion only as an address. It is compared with a programmed value and is never stored. On a match the rest of the frame is stored. On a mismatch the rest of the frame is ignored and MISO is held high. A byte that completes while the buffer is full is lost. The sticky overflow flag is then set either at once, or at the point in the read stream where the lost byte would have appeared.

The control path is a four-state machine. IDLE waits for select to fall, then goes to ADDR_BYTE in the address format or to DATA_BYTES otherwise. ADDR_BYTE goes to DATA_BYTES on an address match or to REJECT on a mismatch, when its eighth bit is sampled. Every state returns to IDLE when select is released.

Top module: `spi_tgt_engine`

## Requirements
- R1: With polarity p and phase h, the leading SCK edge is rising when p=0 and falling when p=1. MOSI is sampled on the leading edge when h=0 and on the trailing edge when h=1. MISO changes on the other edge. All four modes 0..3 (mode = 2p+h) transfer data correctly in both directions.
- R2: With `cfg_lsb_first`=0 the most significant bit of each byte is sent and received first. With 1 the least significant bit is first.
- R3: With phase 0, the first bit of the first transmit byte is on MISO before the first SCK edge of the frame. With phase 1, the first SCK edge of the frame does not advance MISO.
- R4: Releasing select (`ss_n_i`=1) returns the engine to IDLE, clears the bit count and discards any partial byte. The next frame starts cleanly.
- R5: When `cfg_form` equals 4'h2 (address format), the first byte of a frame is compared with `cfg_addr` and is not stored. When it matches, the following bytes of the frame are stored.
- R6: In the address format, an address mismatch discards all further bytes of the frame and drives MISO high until select is released.
- R7: Every `cfg_form` value other than 4'h2 behaves as the plain format, in which every byte is stored.
- R8: The receive buffer holds two bytes. It presents them oldest first on `rx_data_o` with `rx_valid_o`, and removes the head on a cycle with `rx_valid_o` and `rx_ready_i` both high.
- R9: A byte that completes while the buffer is full and not being read is dropped. With `cfg_ovf_now`=1, `ovf_o` is high from the clock edge of the drop.
- R10: With `cfg_ovf_now`=0, `ovf_o` rises on the clock edge that reads the stored byte just before the lost one.
- R11: `ovf_o` stays high until a cycle with `ovf_clr_i`=1 clears it.
- R12: `tx_take_o` pulses once when select falls. After that it pulses once per further transmit byte: with phase 0 at the change edge that ends each byte (1+n pulses for n bytes), and with phase 1 at the first change edge of each byte after the first (n pulses).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| ss_n_i | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to the host |
| cfg_cpol | input | 1 | Clock polarity (idle level) |
| cfg_cpha | input | 1 | Clock phase (0: sample on leading edge) |
| cfg_lsb_first | input | 1 | Bit order (1: least significant bit first) |
| cfg_form | input | 4 | Frame format code; 4'h2 selects the address format |
| cfg_addr | input | 8 | Address compared with the first byte in the address format |
| cfg_ovf_now | input | 1 | Overflow timing (1: immediate, 0: stream aligned) |
| tx_byte_i | input | 8 | Holding byte for transmission |
| tx_take_o | output | 1 | Pulse when `tx_byte_i` is loaded |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | Buffer holds at least one byte |
| rx_ready_i | input | 1 | Consumer accepts the head byte |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clears `ovf_o` |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. A released select forces IDLE with a zero bit count, REJECT persists while select is held, the buffer never exceeds its depth and its head is stable while stalled, an immediate-mode drop raises the flag on the next edge, and the flag stays set until cleared. Only the bench scenarios can show end-to-end behaviour. This covers the byte values moved in all four clock modes and both bit orders, the address compare and its rejection with MISO forced high, reserved format codes acting as plain frames, and the stream-aligned overflow rising on the read of the byte before the lost one.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_DATA   = 2'd2,
        ST_REJECT = 2'd3
    } tgt_state_e;

    localparam logic [3:0] FORM_WITH_ADDR = 4'h2;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
    import spi_tgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          ss_n_s,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          addr_mode,
    input  logic [DW-1:0] cfg_addr,
    input  logic [DW-1:0] tx_byte_i,
    output logic          tx_take_o,
    output logic          miso_o,
    output logic          push_o,
    output logic [DW-1:0] push_data_o
);
    localparam int            CW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    tgt_state_e    state, state_nx;
    logic          sck_q, ss_q;
    logic [CW-1:0] bitcnt, ocnt;
    logic          first;
    logic [DW-1:0] rx_sr, tx_sr, rx_next;
    logic          rise, fall, lead, trail, samp, chg;
    logic          ss_fall, active, byte_done, adv, load;

    // edge classification
    always_comb begin
        rise      = sck_s & ~sck_q;
        fall      = ~sck_s & sck_q;
        lead      = cpol ? fall : rise;
        trail     = cpol ? rise : fall;
        samp      = cpha ? trail : lead;
        chg       = cpha ? lead : trail;
        ss_fall   = ss_q & ~ss_n_s;
        active    = (state != ST_IDLE) && !ss_n_s;
        byte_done = active && samp && (bitcnt == LAST);
        rx_next   = lsb_first ? {mosi_s, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], mosi_s};
        adv       = active && chg && !(cpha && first);
        load      = ((state == ST_IDLE) && ss_fall) ||
                    (adv && (ocnt == LAST) && (state != ST_REJECT));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (ss_fall) state_nx = addr_mode ? ST_ADDR : ST_DATA;
            ST_ADDR: begin
                if (ss_n_s)         state_nx = ST_IDLE;
                else if (byte_done) state_nx = (rx_next == cfg_addr) ? ST_DATA : ST_REJECT;
            end
            ST_DATA:   if (ss_n_s) state_nx = ST_IDLE;
            ST_REJECT: if (ss_n_s) state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            ss_q   <= 1'b1;
            bitcnt <= '0;
            ocnt   <= '0;
            first  <= 1'b1;
            rx_sr  <= '0;
            tx_sr  <= '0;
        end else begin
            sck_q <= sck_s;
            ss_q  <= ss_n_s;
            if ((state == ST_IDLE) || ss_n_s) begin
                bitcnt <= '0;
                ocnt   <= '0;
                first  <= 1'b1;
                if (load) tx_sr <= tx_byte_i;
            end else begin
                if (samp) begin
                    rx_sr  <= rx_next;
                    bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + CW'(1);
                end
                if (chg) first <= 1'b0;
                if (adv) ocnt <= (ocnt == LAST) ? '0 : ocnt + CW'(1);
                if (load) tx_sr <= tx_byte_i;
            end
        end
    end

    // outputs
    always_comb begin
        tx_take_o   = load;
        miso_o      = (state == ST_REJECT) ? 1'b1
                    : tx_sr[lsb_first ? ocnt : (LAST - ocnt)];
        push_o      = (state == ST_DATA) && byte_done;
        push_data_o = rx_next;
    end

    // R4: a released select brings the machine back to IDLE
    assert_idle_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_s |=> (state == ST_IDLE));
    // R4: the bit count restarts after release
    assert_count_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_s |=> (bitcnt == '0));
    // R6: a rejected frame stays rejected while select is held
    assert_reject_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_REJECT) && !ss_n_s) |=> (state == ST_REJECT));
endmodule

// File: rtl/spi_tgt_rxbuf.sv
module spi_tgt_rxbuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    input  logic          imm_i,
    input  logic          clr_i,
    output logic          ovf_o
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] lost;
    logic [AW-1:0]    wr_ptr, rd_ptr, newest;
    logic [CNTW-1:0]  count;
    logic             full, pop, drop, accept, stream_hit, set_ovf;

    always_comb begin
        full       = (count == CNTW'(DEPTH));
        valid_o    = (count != '0);
        data_o     = mem[rd_ptr];
        pop        = valid_o && ready_i;
        drop       = push_i && full && !pop;
        accept     = push_i && !drop;
        newest     = wr_ptr - AW'(1);
        stream_hit = pop && lost[rd_ptr];
        set_ovf    = imm_i ? drop : stream_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            lost   <= '0;
            ovf_o  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr]  <= data_i;
                lost[wr_ptr] <= 1'b0;
                wr_ptr       <= wr_ptr + AW'(1);
            end
            if (drop) lost[newest] <= 1'b1;
            if (pop) rd_ptr <= rd_ptr + AW'(1);
            if (accept && !pop)      count <= count + CNTW'(1);
            else if (!accept && pop) count <= count - CNTW'(1);
            if (set_ovf)    ovf_o <= 1'b1;
            else if (clr_i) ovf_o <= 1'b0;
        end
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(DEPTH));
    assert_head_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
    assert_imm_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_i && push_i && full && !ready_i) |=> ovf_o);
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int RX_DEPTH    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic          ss_n_i,
    output logic          miso_o,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          cfg_lsb_first,
    input  logic [3:0]    cfg_form,
    input  logic [DW-1:0] cfg_addr,
    input  logic          cfg_ovf_now,
    input  logic [DW-1:0] tx_byte_i,
    output logic          tx_take_o,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_valid_o,
    input  logic          rx_ready_i,
    output logic          ovf_o,
    input  logic          ovf_clr_i
);
    logic [2:0]    pins_s;
    logic          push;
    logic [DW-1:0] push_data;
    logic          addr_mode;

    assign addr_mode = (cfg_form == FORM_WITH_ADDR);

    spi_tgt_sync #(
        .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ss_n_i, mosi_i, sck_i}),
        .q_o   (pins_s)
    );

    spi_tgt_shifter #(.DW(DW)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (pins_s[0]),
        .mosi_s      (pins_s[1]),
        .ss_n_s      (pins_s[2]),
        .cpol        (cfg_cpol),
        .cpha        (cfg_cpha),
        .lsb_first   (cfg_lsb_first),
        .addr_mode   (addr_mode),
        .cfg_addr    (cfg_addr),
        .tx_byte_i   (tx_byte_i),
        .tx_take_o   (tx_take_o),
        .miso_o      (miso_o),
        .push_o      (push),
        .push_data_o (push_data)
    );

    spi_tgt_rxbuf #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (push_data),
        .ready_i (rx_ready_i),
        .valid_o (rx_valid_o),
        .data_o  (rx_data_o),
        .imm_i   (cfg_ovf_now),
        .clr_i   (ovf_clr_i),
        .ovf_o   (ovf_o)
    );
endmodule

// File: tb/spi_tgt_engine_bench.sv
module spi_tgt_engine_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic       miso;
    logic       cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic [3:0] form = 4'h0;
    logic [7:0] addr = 8'hA5;
    logic       ovf_now = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_take;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       ovf;
    logic       ovf_clr = 1'b0;

    int errors = 0;
    int checks = 0;
    int takes = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_tgt_engine u_spi_tgt_engine (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
        .miso_o(miso), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb),
        .cfg_form(form), .cfg_addr(addr), .cfg_ovf_now(ovf_now),
        .tx_byte_i(tx_byte), .tx_take_o(tx_take), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .ovf_o(ovf),
        .ovf_clr_i(ovf_clr)
    );

    always @(posedge clk) if (rst_n && tx_take) takes++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // host side: n bits of mo, returns the bits seen on MISO
    task automatic xfer(input logic [7:0] mo, input int nbits, input logic [7:0] nxt,
                        output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            int pos = lsb ? i : 7 - i;
            if (!cpha) begin
                mosi = mo[pos];
                wait_clk(H);
                mi[pos] = miso;
                sck = ~cpol;
                wait_clk(H);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mo[pos];
                wait_clk(H);
                mi[pos] = miso;
                sck = cpol;
            end
            wait_clk(H);
            if (i == 3) tx_byte = nxt;
        end
    endtask

    task automatic frame_begin();
        sck = cpol;
        wait_clk(10);
        ss_n = 1'b0;
        wait_clk(10);
    endtask

    task automatic frame_end();
        wait_clk(H);
        ss_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic pop_chk(input logic [7:0] exp, input string req);
        chk(rx_valid === 1'b1 && rx_data === exp, req, {rx_valid, rx_data}, {1'b1, exp});
        rx_ready = 1'b1;
        wait_clk(1);
        rx_ready = 1'b0;
    endtask

    task automatic empty_chk(input string req);
        chk(rx_valid === 1'b0, req, rx_valid, 0);
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1, r2, a, b, c, d;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // reset state
        chk(rx_valid === 1'b0 && ovf === 1'b0 && tx_take === 1'b0, "R8 reset",
            {rx_valid, ovf, tx_take}, 0);

        // R1 R2 R3 R12: all modes, both orders, two-byte plain frames
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
                cpol = m[1]; cpha = m[0]; lsb = o[0]; form = 4'h0;
                a = 8'(8'h35 + m * 37 + o * 11);
                b = ~a ^ 8'h5A;
                c = 8'(8'hC3 + m * 29 + o * 7);
                d = 8'(c * 3 + 1);
                tx_byte = c;
                frame_begin();
                takes = 0;
                xfer(a, 8, d, r0);
                xfer(b, 8, d, r1);
                frame_end();
                chk(r0 === c, "R1 R3 first miso byte", r0, c);
                chk(r1 === d, "R2 second miso byte", r1, d);
                chk(takes == (cpha ? 1 : 2) , "R12 take pulses", takes, cpha ? 1 : 2);
                pop_chk(a, "R1 R2 rx byte 0");
                pop_chk(b, "R8 rx byte 1");
                empty_chk("R8 empty after reads");
            end
        end

        // R4: partial byte discarded
        cpol = 0; cpha = 0; lsb = 0; form = 4'h0;
        frame_begin();
        xfer(8'hFF, 3, 8'h00, r0);
        frame_end();
        empty_chk("R4 partial byte not stored");
        frame_begin();
        xfer(8'h6C, 8, 8'h00, r0);
        frame_end();
        pop_chk(8'h6C, "R4 clean restart");
        empty_chk("R4 single byte");

        // R7: reserved codes act as plain frames
        for (int f = 0; f < 16; f++) begin
            if (f == 2) continue;
            form = 4'(f);
            frame_begin();
            xfer(8'(8'h10 + f), 8, 8'h00, r0);
            frame_end();
            pop_chk(8'(8'h10 + f), "R7 plain byte stored");
        end

        // R5: address match
        form = 4'h2; addr = 8'hA5; cpha = 1;
        frame_begin();
        xfer(8'hA5, 8, 8'h00, r0);
        xfer(8'h3C, 8, 8'h00, r0);
        xfer(8'h99, 8, 8'h00, r0);
        frame_end();
        pop_chk(8'h3C, "R5 first data byte");
        pop_chk(8'h99, "R5 second data byte");
        empty_chk("R5 address byte not stored");

        // R6: address mismatch
        tx_byte = 8'h00;
        frame_begin();
        xfer(8'hA4, 8, 8'h00, r0);
        xfer(8'h3C, 8, 8'h00, r1);
        xfer(8'h77, 8, 8'h00, r2);
        frame_end();
        chk(r1 === 8'hFF, "R6 miso high byte 1", r1, 8'hFF);
        chk(r2 === 8'hFF, "R6 miso high byte 2", r2, 8'hFF);
        empty_chk("R6 rejected frame not stored");
        frame_begin();
        xfer(8'hA5, 8, 8'h00, r0);
        xfer(8'h42, 8, 8'h00, r0);
        frame_end();
        pop_chk(8'h42, "R4 R5 match after rejected frame");

        // R9 R11: immediate overflow
        form = 4'h0; cpha = 0; ovf_now = 1;
        frame_begin();
        xfer(8'h01, 8, 8'h00, r0);
        xfer(8'h02, 8, 8'h00, r0);
        chk(ovf === 1'b0, "R9 no flag while not full", ovf, 0);
        xfer(8'h03, 8, 8'h00, r0);
        chk(ovf === 1'b1, "R9 flag at drop", ovf, 1);
        frame_end();
        pop_chk(8'h01, "R9 kept byte 0");
        pop_chk(8'h02, "R9 kept byte 1");
        empty_chk("R9 third byte dropped");
        chk(ovf === 1'b1, "R11 flag sticky", ovf, 1);
        ovf_clr = 1'b1; wait_clk(1); ovf_clr = 1'b0;
        chk(ovf === 1'b0, "R11 flag cleared", ovf, 0);

        // R10: stream-aligned overflow
        ovf_now = 0;
        frame_begin();
        xfer(8'h11, 8, 8'h00, r0);
        xfer(8'h22, 8, 8'h00, r0);
        xfer(8'h33, 8, 8'h00, r0);
        frame_end();
        chk(ovf === 1'b0, "R10 no flag at drop", ovf, 0);
        pop_chk(8'h11, "R10 byte 0");
        chk(ovf === 1'b0, "R10 no flag after first read", ovf, 0);
        pop_chk(8'h22, "R10 byte 1");
        chk(ovf === 1'b1, "R10 flag at read before loss", ovf, 1);
        empty_chk("R10 lost byte absent");
        ovf_clr = 1'b1; wait_clk(1); ovf_clr = 1'b0;
        chk(ovf === 1'b0, "R11 cleared again", ovf, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule